// File: doc/BRIEF.md
# Serial Receive Character Queue with Flow-Control Thresholds

This block buffers the characters one channel of an asynchronous serial port receives. Each accepted character goes into a small circular store together with a status byte. The status byte holds the line errors that the deserializer reported, a special-character match code, and a marker that is set when the line has gone idle. The host reads the oldest entry on the read outputs and removes it with a one-cycle pop strobe.

Two fill levels are watched, and each has its own threshold. When the store reaches the service level, a service request goes to the host. When it reaches the higher flow level, the RTS output is withdrawn in hardware so that the far end stops sending. RTS returns as soon as the level falls back below that threshold.

An idle timer handles characters that sit below the service level. It counts prescaler ticks after the last arrival. When the count expires, it marks the newest stored character and raises a timeout request. The host can then collect a short message without waiting for the service level to be reached.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds up to DEPTH (default 12) characters. `fill_level` always shows how many are stored, and a write and a pop in the same cycle leave it unchanged.
- R2: `rd_data` shows the oldest stored character without a pop. Each `pop` removes exactly that entry, and characters come out in arrival order.
- R3: A `wr_vld` that arrives while the queue is full and no pop is made is dropped. The level stays at DEPTH and status bit 0 of the newest stored entry becomes 1. If a pop is made in the same cycle, the character is accepted.
- R4: Each stored status byte is laid out as follows. Bit 0 is overrun, bit 1 is framing error, bit 2 is parity error and bit 3 is break, taken from `wr_err[0]`..`wr_err[3]`. Bits 6:4 hold `wr_match`, with 1 to 4 meaning special characters 1 to 4 and 7 meaning a range match. Bit 7 is the idle-timeout marker and is 0 when the entry is written.
- R5: `svc_req` is 1 exactly when the level is at least SVC_LEVEL (default 6).
- R6: `rts_ok` is 0 exactly when the level is at least FLOW_LEVEL (default 7), and 1 otherwise.
- R7: Qualifying ticks are counted after each write. A tick qualifies when the queue is non-empty, the level is below SVC_LEVEL, and `idle_limit` is nonzero. On the `idle_limit`-th qualifying tick, bit 7 of the newest entry is set and `timeout_req` goes to 1. The timer then stays quiet until the next write. `timeout_req` clears on the next pop or write.
- R8: A tick in a cycle with a write or a pop does not count. An `idle_limit` of 0 disables the timeout.
- R9: A pop on an empty queue changes nothing. While the queue is empty, `rd_data` and `rd_status` read 0.
- R10: After reset the queue is empty, `svc_req` is 0, `rts_ok` is 1 and `timeout_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_vld | input | 1 | Character strobe from the deserializer |
| wr_data | input | DATA_W (8) | Received character |
| wr_err | input | 4 | {break, parity, framing, overrun} flags |
| wr_match | input | 3 | Special-character match code |
| pop | input | 1 | Host removes the oldest entry |
| tick | input | 1 | Prescaler tick for the idle timer |
| idle_limit | input | TMO_W (8) | Idle timeout in qualifying ticks, 0 disables |
| rd_data | output | DATA_W (8) | Oldest character, 0 when empty |
| rd_status | output | 8 | Status byte of the oldest character, 0 when empty |
| fill_level | output | CNT_W (4) | Number of stored characters |
| svc_req | output | 1 | Service request |
| rts_ok | output | 1 | RTS asserted (1) or withdrawn (0) |
| timeout_req | output | 1 | Idle timeout request |

## Verification
Marking the newest entry is the hardest case to reach from the ports. An overrun mark or an idle mark on the newest entry only becomes visible after every older entry has been popped. The timeout also needs a long run of cycles with ticks and no writes or pops, and that run must happen while the level stays below the service level. The stimulus therefore fills the queue to full, pushes extra characters into it, and then pops down to the last entry. It also sets up idle windows with a small limit, with and without pops mixed into the ticking cycles. A long random phase with a varying limit follows, and a behavioural queue model is compared against the outputs on every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int STAT_W = 8;

   typedef struct packed {
      logic       tmo;
      logic [2:0] match;
      logic       brk;
      logic       par;
      logic       frm;
      logic       ovr;
   } rxq_stat_t;

   function automatic rxq_stat_t make_stat(input logic [3:0] err, input logic [2:0] match);
      rxq_stat_t s;
      s.tmo   = 1'b0;
      s.match = match;
      s.brk   = err[3];
      s.par   = err[2];
      s.frm   = err[1];
      s.ovr   = err[0];
      return s;
   endfunction
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 12,
   parameter int DATA_W = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  rxq_stat_t         wstat,
   input  logic              set_ovr,
   input  logic              set_tmo,
   input  logic [PTR_W-1:0]  maddr,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata,
   output rxq_stat_t         rstat
);
   logic [DATA_W-1:0] mem_data [DEPTH];
   rxq_stat_t         mem_stat [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_data[waddr] <= wdata;
         mem_stat[waddr] <= wstat;
      end
      if (set_ovr) mem_stat[maddr].ovr <= 1'b1;
      if (set_tmo) mem_stat[maddr].tmo <= 1'b1;
   end

   assign rdata = mem_data[raddr];
   assign rstat = mem_stat[raddr];
endmodule

// File: rtl/rxq_occupancy.sv
module rxq_occupancy #(
   parameter int DEPTH      = 12,
   parameter int SVC_LEVEL  = 6,
   parameter int FLOW_LEVEL = 7,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_vld,
   input  logic             pop,
   output logic             push,
   output logic             pop_eff,
   output logic             mark_ovr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] newest_ptr,
   output logic [CNT_W-1:0] level,
   output logic             empty,
   output logic             svc_req,
   output logic             rts_ok
);
   localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_L = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] SVC_L  = CNT_W'(SVC_LEVEL);
   localparam logic [CNT_W-1:0] FLOW_L = CNT_W'(FLOW_LEVEL);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic [PTR_W-1:0] wp_q, rp_q, wp_nxt, rp_nxt;
   logic [CNT_W-1:0] lvl_q;
   logic             full;

   generate
      if (POW2) begin : g_pow2
         assign wp_nxt     = wp_q + 1'b1;
         assign rp_nxt     = rp_q + 1'b1;
         assign newest_ptr = wp_q - 1'b1;
      end else begin : g_wrap
         assign wp_nxt     = (wp_q == LAST) ? '0 : wp_q + 1'b1;
         assign rp_nxt     = (rp_q == LAST) ? '0 : rp_q + 1'b1;
         assign newest_ptr = (wp_q == '0) ? LAST : wp_q - 1'b1;
      end
   endgenerate

   assign empty    = (lvl_q == '0);
   assign full     = (lvl_q == FULL_L);
   assign pop_eff  = pop & ~empty;
   assign push     = wr_vld & (~full | pop_eff);
   assign mark_ovr = wr_vld & full & ~pop_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (push)    wp_q <= wp_nxt;
         if (pop_eff) rp_q <= rp_nxt;
         case ({push, pop_eff})
            2'b10:   lvl_q <= lvl_q + CNT_W'(1);
            2'b01:   lvl_q <= lvl_q - CNT_W'(1);
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   assign wr_ptr  = wp_q;
   assign rd_ptr  = rp_q;
   assign level   = lvl_q;
   assign svc_req = (lvl_q >= SVC_L);
   assign rts_ok  = (lvl_q < FLOW_L);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int DEPTH     = 12,
   parameter int SVC_LEVEL = 6,
   parameter int TMO_W     = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_vld,
   input  logic             pop,
   input  logic             tick,
   input  logic [TMO_W-1:0] limit,
   input  logic [CNT_W-1:0] level,
   output logic             fire,
   output logic             timeout_req
);
   localparam logic [CNT_W-1:0] SVC_L = CNT_W'(SVC_LEVEL);

   logic [TMO_W-1:0] cnt_q;
   logic             armed_q, req_q, qual;

   assign qual = tick & armed_q & ~wr_vld & ~pop & (level != '0) &
                 (level < SVC_L) & (limit != '0);
   assign fire = qual & (cnt_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         if (wr_vld) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else if (fire) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (qual) begin
            cnt_q   <= cnt_q + 1'b1;
         end
         if (fire)                req_q <= 1'b1;
         else if (wr_vld || pop)  req_q <= 1'b0;
      end
   end

   assign timeout_req = req_q;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
   import rxq_pkg::*;
#(
   parameter int DEPTH      = 12,
   parameter int DATA_W     = 8,
   parameter int SVC_LEVEL  = 6,
   parameter int FLOW_LEVEL = 7,
   parameter int TMO_W      = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [3:0]        wr_err,
   input  logic [2:0]        wr_match,
   input  logic              pop,
   input  logic              tick,
   input  logic [TMO_W-1:0]  idle_limit,
   output logic [DATA_W-1:0] rd_data,
   output logic [7:0]        rd_status,
   output logic [CNT_W-1:0]  fill_level,
   output logic              svc_req,
   output logic              rts_ok,
   output logic              timeout_req
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_queue: DEPTH must be at least 2");
      end
      if (SVC_LEVEL < 1 || SVC_LEVEL > DEPTH) begin : g_bad_svc
         $error("rx_char_queue: SVC_LEVEL out of range");
      end
      if (FLOW_LEVEL < SVC_LEVEL || FLOW_LEVEL > DEPTH) begin : g_bad_flow
         $error("rx_char_queue: FLOW_LEVEL must lie between SVC_LEVEL and DEPTH");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("rx_char_queue: TMO_W must be positive");
      end
   endgenerate

   logic             push, pop_eff, mark_ovr, empty, fire;
   logic [PTR_W-1:0] wr_ptr, rd_ptr, newest_ptr;
   logic [DATA_W-1:0] head_data;
   rxq_stat_t        head_stat, in_stat;

   assign in_stat = make_stat(wr_err, wr_match);

   rxq_occupancy #(
      .DEPTH(DEPTH), .SVC_LEVEL(SVC_LEVEL), .FLOW_LEVEL(FLOW_LEVEL)
   ) occ_i (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .pop(pop),
      .push(push), .pop_eff(pop_eff), .mark_ovr(mark_ovr),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .newest_ptr(newest_ptr),
      .level(fill_level), .empty(empty), .svc_req(svc_req), .rts_ok(rts_ok)
   );

   rxq_idle_timer #(
      .DEPTH(DEPTH), .SVC_LEVEL(SVC_LEVEL), .TMO_W(TMO_W)
   ) tmr_i (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .pop(pop), .tick(tick),
      .limit(idle_limit), .level(fill_level), .fire(fire),
      .timeout_req(timeout_req)
   );

   rxq_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) mem_i (
      .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_data), .wstat(in_stat),
      .set_ovr(mark_ovr), .set_tmo(fire), .maddr(newest_ptr),
      .raddr(rd_ptr), .rdata(head_data), .rstat(head_stat)
   );

   assign rd_data   = empty ? '0 : head_data;
   assign rd_status = empty ? '0 : head_stat;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DEPTH      = 12,
   parameter int DATA_W     = 8,
   parameter int SVC_LEVEL  = 6,
   parameter int FLOW_LEVEL = 7,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_vld,
   input logic              pop,
   input logic              tick,
   input logic [DATA_W-1:0] rd_data,
   input logic [7:0]        rd_status,
   input logic [CNT_W-1:0]  fill_level,
   input logic              svc_req,
   input logic              rts_ok,
   input logic              timeout_req
);
   p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= CNT_W'(DEPTH));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == CNT_W'(DEPTH) && wr_vld && !pop) |=> fill_level == CNT_W'(DEPTH));

   p_svc_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(svc_req) |-> $past(wr_vld));

   p_rts_above_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rts_ok |-> svc_req);

   p_rts_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rts_ok) |-> $past(wr_vld));

   p_tmo_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_req) |-> ($past(tick) && !$past(wr_vld) && !$past(pop)));

   p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == '0 && pop && !wr_vld) |=> fill_level == '0);

   p_empty_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == '0) |-> (rd_data == '0 && rd_status == '0));
endmodule

bind rx_char_queue rxq_checker #(
   .DEPTH(DEPTH), .DATA_W(DATA_W), .SVC_LEVEL(SVC_LEVEL), .FLOW_LEVEL(FLOW_LEVEL)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .pop(pop), .tick(tick),
   .rd_data(rd_data), .rd_status(rd_status), .fill_level(fill_level),
   .svc_req(svc_req), .rts_ok(rts_ok), .timeout_req(timeout_req)
);

// File: tb/rx_char_queue_tb_top.sv
module rx_char_queue_tb_top;
   localparam int DEPTH = 12;
   localparam int SVC   = 6;
   localparam int FLOW  = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_vld = 1'b0;
   logic [7:0] wr_data = '0;
   logic [3:0] wr_err = '0;
   logic [2:0] wr_match = '0;
   logic       pop = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] idle_limit = '0;
   logic [7:0] rd_data, rd_status;
   logic [3:0] fill_level;
   logic       svc_req, rts_ok, timeout_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] q[$];
   int  m_cnt = 0;
   bit  m_armed = 0;
   bit  m_treq = 0;

   always #10 clk = ~clk;

   rx_char_queue dut_i (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_data(wr_data),
      .wr_err(wr_err), .wr_match(wr_match), .pop(pop), .tick(tick),
      .idle_limit(idle_limit), .rd_data(rd_data), .rd_status(rd_status),
      .fill_level(fill_level), .svc_req(svc_req), .rts_ok(rts_ok),
      .timeout_req(timeout_req)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [15:0] head;
      int n = q.size();
      head = (n > 0) ? q[0] : 16'h0;
      chk("R1 fill_level", 16'(fill_level), 16'(n));
      chk("R2 rd_data", 16'(rd_data), 16'(head[7:0]));
      chk("R4 rd_status", 16'(rd_status), 16'(head[15:8]));
      chk("R5 svc_req", 16'(svc_req), 16'(n >= SVC));
      chk("R6 rts_ok", 16'(rts_ok), 16'(n < FLOW));
      chk("R7 timeout_req", 16'(timeout_req), 16'(m_treq));
   endtask

   task automatic model_step();
      int  n = q.size();
      bit  pe = pop && (n > 0);
      int  lim = idle_limit;
      bit  qual = tick && m_armed && !wr_vld && !pop && n > 0 && n < SVC && lim != 0;
      bit  fire = qual && (m_cnt == lim - 1);
      logic [15:0] t;
      if (pe) void'(q.pop_front());
      if (wr_vld) begin
         if (n < DEPTH || pe) q.push_back({1'b0, wr_match, wr_err, wr_data});
         else begin t = q[q.size()-1]; t[8] = 1'b1; q[q.size()-1] = t; end
      end
      if (fire) begin t = q[q.size()-1]; t[15] = 1'b1; q[q.size()-1] = t; end
      if (wr_vld) begin m_cnt = 0; m_armed = 1; end
      else if (fire) begin m_cnt = 0; m_armed = 0; end
      else if (qual) m_cnt++;
      if (fire) m_treq = 1;
      else if (wr_vld || pop) m_treq = 0;
   endtask

   // drive one cycle of stimulus, advance model, compare after the edge
   task automatic cyc(input bit w, input logic [7:0] d, input logic [3:0] e,
                      input logic [2:0] m, input bit p, input bit t);
      wr_vld = w; wr_data = d; wr_err = e; wr_match = m; pop = p; tick = t;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 level after reset", 16'(fill_level), 16'h0);
      chk("R10 svc_req after reset", 16'(svc_req), 16'h0);
      chk("R10 rts_ok after reset", 16'(rts_ok), 16'h1);
      chk("R10 timeout_req after reset", 16'(timeout_req), 16'h0);

      // R2/R4: status layout and ordering
      cyc(1, 8'hA1, 4'b0001, 3'd1, 0, 0);
      cyc(1, 8'hB2, 4'b0110, 3'd4, 0, 0);
      cyc(1, 8'hC3, 4'b1000, 3'd7, 0, 0);
      chk("R4 head status bits", 16'(rd_status), 16'h11);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R2 second in order", 16'(rd_data), 16'hB2);
      chk("R4 parity+framing+match4", 16'(rd_status), 16'h46);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R4 break+range match", 16'(rd_status), 16'h78);
      cyc(0, 0, 0, 0, 1, 0);

      // R9: empty pop
      cyc(0, 0, 0, 0, 1, 0);
      chk("R9 empty pop level", 16'(fill_level), 16'h0);
      chk("R9 empty rd_data", 16'(rd_data), 16'h0);

      // R5/R6/R3: fill past thresholds, then overrun
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1, 8'(8'h10 + i), 4'b0000, 3'd0, 0, 0);
         if (i == SVC - 1) chk("R5 svc at level 6", 16'(svc_req), 16'h1);
         if (i == SVC - 1) chk("R6 rts still on at 6", 16'(rts_ok), 16'h1);
         if (i == FLOW - 1) chk("R6 rts off at 7", 16'(rts_ok), 16'h0);
      end
      cyc(1, 8'hEE, 4'b0000, 3'd0, 0, 0);
      cyc(1, 8'hEF, 4'b0000, 3'd0, 0, 0);
      chk("R3 level held at full", 16'(fill_level), 16'(DEPTH));
      cyc(1, 8'h77, 4'b0000, 3'd2, 1, 0);
      chk("R3 pop+write when full keeps level", 16'(fill_level), 16'(DEPTH));
      for (int i = 0; i < DEPTH - 1; i++) begin
         cyc(0, 0, 0, 0, 1, 0);
         if (i == DEPTH - FLOW) chk("R6 rts back below 7", 16'(rts_ok), 16'h1);
      end
      chk("R3 accepted char at head", 16'(rd_data), 16'h77);
      cyc(0, 0, 0, 0, 1, 0);

      // R3 overrun mark on newest stored entry
      for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i), 4'b0000, 3'd0, 0, 0);
      cyc(1, 8'hFF, 4'b0000, 3'd0, 0, 0);
      for (int i = 0; i < DEPTH - 1; i++) cyc(0, 0, 0, 0, 1, 0);
      chk("R3 overrun bit on newest", 16'(rd_status[0]), 16'h1);
      chk("R3 newest data kept", 16'(rd_data), 16'(DEPTH - 1));
      cyc(0, 0, 0, 0, 1, 0);

      // R7: timeout after 3 qualifying ticks
      idle_limit = 8'd3;
      cyc(1, 8'h41, 0, 0, 0, 0);
      cyc(1, 8'h42, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R7 not yet fired", 16'(timeout_req), 16'h0);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R7 timeout_req raised", 16'(timeout_req), 16'h1);
      cyc(0, 0, 0, 0, 0, 1);
      idle(3);
      chk("R7 stays set, fires once", 16'(timeout_req), 16'h1);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R7 cleared by pop", 16'(timeout_req), 16'h0);
      chk("R7 marker on newest entry", 16'(rd_status[7]), 16'h1);
      cyc(0, 0, 0, 0, 1, 0);

      // R8: ticks with pop do not count; limit 0 disables
      idle_limit = 8'd2;
      cyc(1, 8'h51, 0, 0, 0, 0);
      cyc(1, 8'h52, 0, 0, 0, 0);
      cyc(1, 8'h53, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 1);
      cyc(0, 0, 0, 0, 1, 1);
      chk("R8 ticks with pop ignored", 16'(timeout_req), 16'h0);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R8 one tick not enough", 16'(timeout_req), 16'h0);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R7 fired after two clean ticks", 16'(timeout_req), 16'h1);
      cyc(0, 0, 0, 0, 1, 0);
      idle_limit = 8'd0;
      cyc(1, 8'h61, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 1);
      chk("R8 limit zero disables", 16'(timeout_req), 16'h0);
      cyc(0, 0, 0, 0, 1, 0);

      // random phase, model compared every cycle
      for (int seg = 0; seg < 40; seg++) begin
         idle_limit = 8'($urandom_range(0, 5));
         for (int i = 0; i < 100; i++) begin
            bit w = ($urandom_range(0, 9) < ((seg % 4 == 0) ? 2 : 5));
            bit p = ($urandom_range(0, 9) < ((seg % 3 == 0) ? 2 : 4));
            cyc(w, 8'($urandom), 4'($urandom), 3'($urandom), p,
                ($urandom_range(0, 2) == 0));
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule